// File: doc/BRIEF.md
# Output Compare Unit with Period Trigger

This block watches a free-running timer count and compares it against a programmable compare value. When the count equals the compare value on a timer tick, a 4-bit mode selects the action. The unit can drive a compare output latch high, drive it low, only raise an interrupt flag, or fire a period trigger. The period trigger clears the timer and, when the converter is enabled, asks an ADC to start a conversion. The timer itself sits outside the block. It runs on the same clock as the compare logic and reports each count step with a tick strobe.

Software writes the compare value and the mode through a small register write port. The compare latch reaches the pin only while the pin direction input selects output. The interrupt flag stays set until software clears it. Writing an all-zero mode forces the compare latch back to its low default.

Top module: `cmp_trig_unit`

## Requirements
- R1: After reset the compare latch, the interrupt flag, the timer clear pulse and the ADC start pulse are all 0, and the mode is 0000 (inactive).
- R2: A match is an exact equality of `tmr_count` and the compare value, sampled on a clock edge where `tmr_tick` is 1. A mismatching count, or an equal count without a tick, has no effect.
- R3: In mode 1000 a match sets the compare latch to 1 and sets the interrupt flag. Both are visible in the cycle after the matching edge.
- R4: In mode 1001 a match clears the compare latch to 0 and sets the interrupt flag in the cycle after the matching edge.
- R5: In mode 1010 a match sets the interrupt flag and leaves the compare latch unchanged.
- R6: In mode 1011 a match drives `tmr_clr` high for exactly one cycle and sets the interrupt flag. The compare latch stays unchanged.
- R7: `adc_go` pulses for one cycle together with the mode 1011 `tmr_clr` pulse, but only if `adc_en` was 1 at the matching edge.
- R8: The interrupt flag stays set until `irq_clr` is asserted. A match on the same edge as `irq_clr` wins, and the flag stays 1.
- R9: A match acts once per equality event. Further ticks while the count still equals the compare value cause no new action. A new action needs a tick with a different count first.
- R10: A mode write of 0000 forces the compare latch to 0 in the cycle after the write.
- R11: `pin_oe` is the inverse of `pin_dir`. `pin_out` carries the compare latch while `pin_dir` is 0 and is 0 while `pin_dir` is 1.
- R12: Mode values outside 1000 to 1011 take no action on a match: no flag, no latch change and no timer clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the compare value, 1 selects the mode |
| wr_data | input | TMR_W | Write data; the mode takes bits [3:0] |
| tmr_tick | input | 1 | Timer count step strobe |
| tmr_count | input | TMR_W | Current timer count |
| adc_en | input | 1 | ADC enabled, gates the start request |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| pin_dir | input | 1 | Pin direction, 0 = output |
| pin_out | output | 1 | Compare output toward the pin |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| tmr_clr | output | 1 | One-cycle timer clear request |
| adc_go | output | 1 | One-cycle ADC start request |

## Verification
The latch, the flag, `tmr_clr` and `adc_go` are each one register stage behind the matching edge. A mode write of zero also reaches the latch one edge later. The pin outputs follow `pin_dir` with no delay. Every bench task drives its stimulus on a falling edge and lets one rising edge pass. It then checks the registered results on the next falling edge, so they are sampled in the single cycle they are due. The one-cycle pulses are sampled again one cycle later to confirm they have dropped.

// File: rtl/cmp_trig_pkg.sv
package cmp_trig_pkg;

   localparam int MODE_W = 4;

   localparam logic [MODE_W-1:0] MODE_OFF      = 4'b0000;
   localparam logic [MODE_W-1:0] MODE_DRIVE_HI = 4'b1000;
   localparam logic [MODE_W-1:0] MODE_DRIVE_LO = 4'b1001;
   localparam logic [MODE_W-1:0] MODE_FLAG     = 4'b1010;
   localparam logic [MODE_W-1:0] MODE_PERIOD   = 4'b1011;

   typedef enum logic {
      SEL_VALUE = 1'b0,
      SEL_MODE  = 1'b1
   } wr_sel_e;

   typedef struct packed {
      logic drive_hi;
      logic drive_lo;
      logic raise_flag;
      logic period;
   } cmp_act_t;

   function automatic cmp_act_t decode_mode(input logic [MODE_W-1:0] m);
      cmp_act_t a;
      a = '0;
      unique case (m)
         MODE_DRIVE_HI: begin a.drive_hi = 1'b1; a.raise_flag = 1'b1; end
         MODE_DRIVE_LO: begin a.drive_lo = 1'b1; a.raise_flag = 1'b1; end
         MODE_FLAG:     begin a.raise_flag = 1'b1; end
         MODE_PERIOD:   begin a.period = 1'b1; a.raise_flag = 1'b1; end
         default:       a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
   import cmp_trig_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [TMR_W-1:0]  wr_data,
   output logic [TMR_W-1:0]  cmp_val,
   output logic [MODE_W-1:0] mode,
   output logic              mode_zero_req
);

   logic value_we;
   logic mode_we;

   assign value_we = wr_en && (wr_addr == SEL_VALUE);
   assign mode_we  = wr_en && (wr_addr == SEL_MODE);

   // a zero mode write forces the compare latch low on the same edge
   assign mode_zero_req = mode_we && (wr_data[MODE_W-1:0] == MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
         mode    <= MODE_OFF;
      end else begin
         if (value_we) cmp_val <= wr_data;
         if (mode_we)  mode    <= wr_data[MODE_W-1:0];
      end
   end

endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
   parameter int TMR_W    = 16,
   parameter int SLICE_W  = 8,
   parameter bit ONE_SHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [TMR_W-1:0] count,
   input  logic [TMR_W-1:0] cmp_val,
   output logic             hit
);

   localparam int N_SLICE = TMR_W / SLICE_W;

   logic [N_SLICE-1:0] slice_eq;
   logic               eq;

   // equality is formed per slice and reduced, keeping the compare tree shallow
   for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
      assign slice_eq[i] = (count[i*SLICE_W +: SLICE_W] == cmp_val[i*SLICE_W +: SLICE_W]);
   end

   assign eq = &slice_eq;

   if (ONE_SHOT) begin : g_edge
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    seen_q <= 1'b0;
         else if (tick) seen_q <= eq;
      end
      assign hit = tick && eq && !seen_q;
   end else begin : g_level
      assign hit = tick && eq;
   end

endmodule

// File: rtl/cmp_action.sv
module cmp_action
   import cmp_trig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [MODE_W-1:0] mode,
   input  logic              mode_zero_req,
   input  logic              irq_clr,
   input  logic              adc_en,
   output logic              cmp_latch,
   output logic              irq_flag,
   output logic              tmr_clr,
   output logic              adc_go
);

   cmp_act_t act;

   assign act = decode_mode(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_latch <= 1'b0;
         irq_flag  <= 1'b0;
         tmr_clr   <= 1'b0;
         adc_go    <= 1'b0;
      end else begin
         if (mode_zero_req)              cmp_latch <= 1'b0;
         else if (hit && act.drive_hi)   cmp_latch <= 1'b1;
         else if (hit && act.drive_lo)   cmp_latch <= 1'b0;

         if (hit && act.raise_flag)      irq_flag <= 1'b1;
         else if (irq_clr)               irq_flag <= 1'b0;

         tmr_clr <= hit && act.period;
         adc_go  <= hit && act.period && adc_en;
      end
   end

endmodule

// File: rtl/cmp_trig_unit.sv
module cmp_trig_unit
   import cmp_trig_pkg::*;
#(
   parameter int TMR_W    = 16,
   parameter int SLICE_W  = 8,
   parameter bit ONE_SHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [TMR_W-1:0] wr_data,
   input  logic             tmr_tick,
   input  logic [TMR_W-1:0] tmr_count,
   input  logic             adc_en,
   input  logic             irq_clr,
   input  logic             pin_dir,
   output logic             pin_out,
   output logic             pin_oe,
   output logic             irq_flag,
   output logic             tmr_clr,
   output logic             adc_go
);

   if (TMR_W < MODE_W) begin : g_bad_width
      $error("cmp_trig_unit: TMR_W must hold the mode field");
   end
   if (SLICE_W < 1 || (TMR_W % SLICE_W) != 0) begin : g_bad_slice
      $error("cmp_trig_unit: SLICE_W must divide TMR_W");
   end

   logic [TMR_W-1:0]  cmp_val;
   logic [MODE_W-1:0] mode;
   logic              mode_zero_req;
   logic              hit;
   logic              cmp_latch;

   cmp_ctrl_regs #(.TMR_W(TMR_W)) regs_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .cmp_val       (cmp_val),
      .mode          (mode),
      .mode_zero_req (mode_zero_req)
   );

   cmp_match_det #(.TMR_W(TMR_W), .SLICE_W(SLICE_W), .ONE_SHOT(ONE_SHOT)) det_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tmr_tick),
      .count   (tmr_count),
      .cmp_val (cmp_val),
      .hit     (hit)
   );

   cmp_action act_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .hit           (hit),
      .mode          (mode),
      .mode_zero_req (mode_zero_req),
      .irq_clr       (irq_clr),
      .adc_en        (adc_en),
      .cmp_latch     (cmp_latch),
      .irq_flag      (irq_flag),
      .tmr_clr       (tmr_clr),
      .adc_go        (adc_go)
   );

   assign pin_oe  = !pin_dir;
   assign pin_out = cmp_latch && !pin_dir;

endmodule

// File: rtl/cmp_trig_unit_chk.sv
module cmp_trig_unit_chk #(
   parameter bit ONE_SHOT = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_addr,
   input logic [3:0] mode_wdata,
   input logic       tmr_tick,
   input logic       adc_en,
   input logic       irq_clr,
   input logic       pin_dir,
   input logic       pin_out,
   input logic       pin_oe,
   input logic       irq_flag,
   input logic       tmr_clr,
   input logic       adc_go
);

   p_pin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pin_dir |-> (!pin_out && !pin_oe));

   p_adc_with_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adc_go |-> (tmr_clr && $past(adc_en)));

   p_clr_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr |-> irq_flag);

   p_clr_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ONE_SHOT && tmr_clr) |=> !tmr_clr);

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   p_flag_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(tmr_tick));

   p_zero_mode_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && mode_wdata == 4'b0000) |=> !pin_out);

endmodule

bind cmp_trig_unit cmp_trig_unit_chk #(.ONE_SHOT(ONE_SHOT)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .mode_wdata (wr_data[3:0]),
   .tmr_tick   (tmr_tick),
   .adc_en     (adc_en),
   .irq_clr    (irq_clr),
   .pin_dir    (pin_dir),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq_flag   (irq_flag),
   .tmr_clr    (tmr_clr),
   .adc_go     (adc_go)
);

// File: tb/cmp_trig_unit_tb_top.sv
module cmp_trig_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TMR_W      = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_addr = 1'b0;
   logic [TMR_W-1:0] wr_data = '0;
   logic             tmr_tick = 1'b0;
   logic [TMR_W-1:0] tmr_count = '0;
   logic             adc_en = 1'b0;
   logic             irq_clr = 1'b0;
   logic             pin_dir = 1'b1;
   logic             pin_out, pin_oe, irq_flag, tmr_clr, adc_go;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_trig_unit #(.TMR_W(TMR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tmr_tick(tmr_tick), .tmr_count(tmr_count), .adc_en(adc_en), .irq_clr(irq_clr),
      .pin_dir(pin_dir), .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag),
      .tmr_clr(tmr_clr), .adc_go(adc_go)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all drivers change on a falling edge; results are read on the following falling edge
   task automatic write_reg(input logic addr, input logic [TMR_W-1:0] data);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step(input logic [TMR_W-1:0] v, input logic clr = 1'b0);
      tmr_count = v; tmr_tick = 1'b1; irq_clr = clr;
      @(posedge clk); @(negedge clk);
      tmr_tick = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic clear_flag();
      irq_clr = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 latch", pin_out, 0);
      check("R1 flag", irq_flag, 0);
      check("R1 tmr_clr", tmr_clr, 0);
      check("R1 adc_go", adc_go, 0);
      pin_dir = 1'b0; #1;
      check("R1 latch low at pin", pin_out, 0);
   endtask

   task automatic t_drive_hi();
      write_reg(1'b0, 16'h1234);
      write_reg(1'b1, 16'h0008);
      step(16'h1233);
      check("R2 mismatch no flag", irq_flag, 0);
      check("R2 mismatch no latch", pin_out, 0);
      step(16'h1234);
      check("R3 latch high", pin_out, 1);
      check("R3 flag set", irq_flag, 1);
   endtask

   task automatic t_drive_lo();
      clear_flag();
      check("R8 flag cleared", irq_flag, 0);
      write_reg(1'b1, 16'h0009);
      step(16'h1000);
      tmr_count = 16'h1234; tmr_tick = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R2 no tick no flag", irq_flag, 0);
      check("R2 no tick latch kept", pin_out, 1);
      step(16'h1234);
      check("R4 latch low", pin_out, 0);
      check("R4 flag set", irq_flag, 1);
   endtask

   task automatic t_flag_only();
      clear_flag();
      write_reg(1'b1, 16'h0008);
      step(16'h0010); step(16'h1234);
      check("R3 latch high again", pin_out, 1);
      write_reg(1'b1, 16'h000A);
      clear_flag();
      step(16'h0011); step(16'h1234);
      check("R5 flag set", irq_flag, 1);
      check("R5 latch unchanged", pin_out, 1);
      clear_flag();
      step(16'h1234);
      check("R9 held equal no retrigger", irq_flag, 0);
      step(16'h1234);
      check("R9 held equal still quiet", irq_flag, 0);
      step(16'h0001); step(16'h1234, 1'b1);
      check("R8 set wins over clear", irq_flag, 1);
      repeat (3) @(negedge clk);
      check("R8 flag sticky", irq_flag, 1);
   endtask

   task automatic t_period();
      clear_flag();
      write_reg(1'b0, 16'h0040);
      write_reg(1'b1, 16'h000B);
      adc_en = 1'b1;
      step(16'h003F);
      check("R6 no clear before match", tmr_clr, 0);
      step(16'h0040);
      check("R6 tmr_clr pulse", tmr_clr, 1);
      check("R7 adc_go with enable", adc_go, 1);
      check("R6 flag set", irq_flag, 1);
      check("R6 latch unchanged", pin_out, 1);
      step(16'h0000);
      check("R6 tmr_clr one cycle", tmr_clr, 0);
      check("R7 adc_go one cycle", adc_go, 0);
      adc_en = 1'b0;
      step(16'h0040);
      check("R6 tmr_clr second period", tmr_clr, 1);
      check("R7 adc_go gated off", adc_go, 0);
      @(negedge clk);
   endtask

   task automatic t_inactive_modes();
      clear_flag();
      write_reg(1'b0, 16'h0200);
      write_reg(1'b1, 16'h0005);
      step(16'h01FF); step(16'h0200);
      check("R12 mode 0101 no flag", irq_flag, 0);
      check("R12 mode 0101 no clear", tmr_clr, 0);
      write_reg(1'b1, 16'h000C);
      step(16'h0001); step(16'h0200);
      check("R12 mode 1100 no flag", irq_flag, 0);
      check("R12 mode 1100 latch kept", pin_out, 1);
   endtask

   task automatic t_pin_dir();
      pin_dir = 1'b1; #1;
      check("R11 oe off as input", pin_oe, 0);
      check("R11 out low as input", pin_out, 0);
      pin_dir = 1'b0; #1;
      check("R11 oe on as output", pin_oe, 1);
      check("R11 latch at pin", pin_out, 1);
   endtask

   task automatic t_mode_zero();
      write_reg(1'b1, 16'h0000);
      check("R10 zero mode forces low", pin_out, 0);
      step(16'h0000); step(16'h0200);
      check("R12 mode 0000 no flag", irq_flag, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_drive_hi();
      t_drive_lo();
      t_flag_only();
      t_period();
      t_inactive_modes();
      t_pin_dir();
      t_mode_zero();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule